// File: doc/BRIEF.md
# Seconds Countdown Alarm

The block holds a seconds count that software loads through a small register port. While counting is enabled, each one-second strobe on `tick_i` takes one off the count. When the count steps from one to zero, a sticky pending flag is raised. That flag drives an interrupt line when its interrupt enable is set. The same interrupt also drives a system wakeup line when the wakeup routing bit is set.

A second, weekly alarm sits beside it. This block does no time matching for it. An external match strobe sets its pending flag when the weekly alarm is enabled. It has its own interrupt enable. Both pending flags clear when software writes a one to them.

Software reprograms the countdown in this order: disable it, clear pending, write zero to the count, wait a short time, write the new count, then re-enable. The port is plain control. A write takes effect at the clock edge where `wr_en_i` is high. A read returns data in the same cycle. There is no back-pressure.

Top module: `secs_alarm`

## Requirements
- R1: After reset the count, all control bits and both pending flags are 0. `irq_cnt_o`, `irq_week_o` and `wake_o` are low.
- R2: A write to address 0x00 loads the count from `wr_data_i`. A read of 0x00 returns the current count.
- R3: The count drops by exactly one on a clock edge where `tick_i` is high, the run bit (0x04 bit 0) is 1 and the count is nonzero. Otherwise it holds.
- R4: The countdown pending flag (0x0C bit 0) is set only on the step from 1 to 0. A count held at zero, or a load of zero, never sets it.
- R5: Writing 1 to bit 0 of 0x0C or 0x1C clears that pending flag. Writing 0 leaves it unchanged.
- R6: If a set event and a clear write hit the same flag at the same edge, the flag ends up set.
- R7: `irq_cnt_o` equals countdown pending AND the interrupt enable at 0x08 bit 0.
- R8: `wake_o` equals `irq_cnt_o` AND the wakeup routing bit at 0x10 bit 0.
- R9: The weekly pending flag (0x1C bit 0) is set by `week_match_i` only when the weekly enable (0x14 bit 0) is 1. `irq_week_o` equals weekly pending AND the weekly interrupt enable at 0x18 bit 0.
- R10: A count write in the same cycle as a qualifying tick loads the written value, and that edge does not set pending.
- R11: Control and status registers read 0 in bits above bit 0. Any address not listed above reads 0 and ignores writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | One-cycle strobe, once per second |
| week_match_i | input | 1 | Weekly match strobe from outside |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | ADDR_W | Write byte address |
| wr_data_i | input | DATA_W | Write data |
| rd_addr_i | input | ADDR_W | Read byte address |
| rd_data_o | output | DATA_W | Read data, combinational |
| irq_cnt_o | output | 1 | Countdown interrupt |
| irq_week_o | output | 1 | Weekly interrupt |
| wake_o | output | 1 | System wakeup request |

## Verification
The hardest cases to reach from the ports need two things at the same edge. One is a tick that takes the count from 1 to 0 while software writes a clear to pending. The other is a tick that lands on a count write. The stimulus builds both cases on purpose: it loads a count of one, enables counting, and drives the tick together with the write. A long random phase then runs with small loaded counts and frequent ticks. This lets expiry, clearing and reloading collide in many orders.

// File: rtl/secs_alarm_pkg.sv
package secs_alarm_pkg;
  localparam logic [7:0] A_COUNT = 8'h00;
  localparam logic [7:0] A_RUN   = 8'h04;
  localparam logic [7:0] A_CIE   = 8'h08;
  localparam logic [7:0] A_CPEND = 8'h0C;
  localparam logic [7:0] A_WAKE  = 8'h10;
  localparam logic [7:0] A_WEN   = 8'h14;
  localparam logic [7:0] A_WIE   = 8'h18;
  localparam logic [7:0] A_WPEND = 8'h1C;

  localparam int NUM_FLAGS = 2;
  localparam int F_CNT  = 0;
  localparam int F_WEEK = 1;

  typedef struct packed {
    logic run;
    logic cie;
    logic wake;
    logic wen;
    logic wie;
  } ctl_t;
endpackage

// File: rtl/secs_alarm_flag.sv
module secs_alarm_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic pend_o
);
  always_ff @(posedge clk) begin
    if (!rst_n)      pend_o <= 1'b0;
    else if (set_i)  pend_o <= 1'b1;
    else if (clr_i)  pend_o <= 1'b0;
  end

  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> pend_o); // R6
  AST_CLEAR_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !set_i) |=> !pend_o); // R5
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_i && !set_i) |=> $stable(pend_o)); // R5
endmodule

// File: rtl/secs_alarm_count.sv
module secs_alarm_count #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             run_i,
  input  logic             ld_i,
  input  logic [CNT_W-1:0] ld_val_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             hit_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic step;
  assign step  = tick_i && run_i && (cnt_o != '0);
  assign hit_o = step && !ld_i && (cnt_o == ONE);

  always_ff @(posedge clk) begin
    if (!rst_n)    cnt_o <= '0;
    else if (ld_i) cnt_o <= ld_val_i;
    else if (step) cnt_o <= cnt_o - ONE;
  end

  AST_DEC_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !ld_i) |=> (cnt_o == $past(cnt_o) - ONE)); // R3
  AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld_i && !(tick_i && run_i)) |=> $stable(cnt_o)); // R3
  AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    ld_i |=> (cnt_o == $past(ld_val_i))); // R10
endmodule

// File: rtl/secs_alarm_regs.sv
module secs_alarm_regs
  import secs_alarm_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 we_i,
  input  logic [ADDR_W-1:0]    waddr_i,
  input  logic                 wbit0_i,
  input  logic [ADDR_W-1:0]    raddr_i,
  input  logic [CNT_W-1:0]     cnt_i,
  input  logic [NUM_FLAGS-1:0] pend_i,
  output ctl_t                 ctl_o,
  output logic                 ld_o,
  output logic [NUM_FLAGS-1:0] clr_o,
  output logic [DATA_W-1:0]    rd_data_o
);
  function automatic logic hit(input logic [ADDR_W-1:0] a, input logic [7:0] k);
    return a == ADDR_W'(k);
  endfunction

  assign ld_o          = we_i && hit(waddr_i, A_COUNT);
  assign clr_o[F_CNT]  = we_i && wbit0_i && hit(waddr_i, A_CPEND);
  assign clr_o[F_WEEK] = we_i && wbit0_i && hit(waddr_i, A_WPEND);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl_o <= '0;
    end else if (we_i) begin
      if (hit(waddr_i, A_RUN))  ctl_o.run  <= wbit0_i;
      if (hit(waddr_i, A_CIE))  ctl_o.cie  <= wbit0_i;
      if (hit(waddr_i, A_WAKE)) ctl_o.wake <= wbit0_i;
      if (hit(waddr_i, A_WEN))  ctl_o.wen  <= wbit0_i;
      if (hit(waddr_i, A_WIE))  ctl_o.wie  <= wbit0_i;
    end
  end

  logic bit0;
  logic is_bit;
  always_comb begin
    bit0   = 1'b0;
    is_bit = 1'b1;
    if      (hit(raddr_i, A_RUN))   bit0 = ctl_o.run;
    else if (hit(raddr_i, A_CIE))   bit0 = ctl_o.cie;
    else if (hit(raddr_i, A_CPEND)) bit0 = pend_i[F_CNT];
    else if (hit(raddr_i, A_WAKE))  bit0 = ctl_o.wake;
    else if (hit(raddr_i, A_WEN))   bit0 = ctl_o.wen;
    else if (hit(raddr_i, A_WIE))   bit0 = ctl_o.wie;
    else if (hit(raddr_i, A_WPEND)) bit0 = pend_i[F_WEEK];
    else                            is_bit = 1'b0;

    if (hit(raddr_i, A_COUNT)) rd_data_o = DATA_W'(cnt_i);
    else if (is_bit)           rd_data_o = DATA_W'(bit0);
    else                       rd_data_o = '0;
  end

  AST_STATUS_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !hit(raddr_i, A_COUNT) |-> (rd_data_o[DATA_W-1:1] == '0)); // R11
endmodule

// File: rtl/secs_alarm.sv
module secs_alarm
  import secs_alarm_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic              week_match_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              irq_cnt_o,
  output logic              irq_week_o,
  output logic              wake_o
);
  ctl_t                 ctl;
  logic                 ld;
  logic [CNT_W-1:0]     cnt;
  logic                 hit;
  logic [NUM_FLAGS-1:0] set;
  logic [NUM_FLAGS-1:0] clr;
  logic [NUM_FLAGS-1:0] pend;

  secs_alarm_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .we_i(wr_en_i), .waddr_i(wr_addr_i),
    .wbit0_i(wr_data_i[0]), .raddr_i(rd_addr_i), .cnt_i(cnt), .pend_i(pend),
    .ctl_o(ctl), .ld_o(ld), .clr_o(clr), .rd_data_o(rd_data_o)
  );

  secs_alarm_count #(.CNT_W(CNT_W)) u_count (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .run_i(ctl.run), .ld_i(ld),
    .ld_val_i(wr_data_i[CNT_W-1:0]), .cnt_o(cnt), .hit_o(hit)
  );

  assign set[F_CNT]  = hit;
  assign set[F_WEEK] = week_match_i && ctl.wen;

  for (genvar g = 0; g < NUM_FLAGS; g++) begin : g_flag
    secs_alarm_flag u_flag (
      .clk(clk), .rst_n(rst_n), .set_i(set[g]), .clr_i(clr[g]), .pend_o(pend[g])
    );
  end

  assign irq_cnt_o  = pend[F_CNT] && ctl.cie;
  assign irq_week_o = pend[F_WEEK] && ctl.wie;
  assign wake_o     = irq_cnt_o && ctl.wake;

  AST_RISE_FROM_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pend[F_CNT]) |-> ($past(cnt) == CNT_W'(1) && cnt == '0)); // R4
  AST_WEEK_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pend[F_WEEK]) |-> $past(week_match_i && ctl.wen)); // R9
  AST_WAKE_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    wake_o |-> (irq_cnt_o && pend[F_CNT])); // R8
endmodule

// File: tb/secs_alarm_bench.sv
`timescale 1ns/1ps
module secs_alarm_bench;
  localparam int AW = 8;
  localparam int DW = 32;

  logic clk = 0, rst_n = 0;
  logic tick = 0, wm = 0, we = 0;
  logic [AW-1:0] wa = '0, ra = '0;
  logic [DW-1:0] wd = '0;
  logic [DW-1:0] rd;
  logic irq_c, irq_w, wake;

  int n_chk = 0, n_fail = 0;

  // model state
  logic [31:0] m_cnt;
  logic m_run, m_cie, m_wake, m_wen, m_wie, m_cp, m_wp;

  always #2.5 clk = ~clk;

  secs_alarm u_secs_alarm (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .week_match_i(wm),
    .wr_en_i(we), .wr_addr_i(wa), .wr_data_i(wd), .rd_addr_i(ra),
    .rd_data_o(rd), .irq_cnt_o(irq_c), .irq_week_o(irq_w), .wake_o(wake)
  );

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual %0h expected %0h", r, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_read(input logic [7:0] a);
    case (a)
      8'h00: return m_cnt;
      8'h04: return {31'd0, m_run};
      8'h08: return {31'd0, m_cie};
      8'h0C: return {31'd0, m_cp};
      8'h10: return {31'd0, m_wake};
      8'h14: return {31'd0, m_wen};
      8'h18: return {31'd0, m_wie};
      8'h1C: return {31'd0, m_wp};
      default: return 32'd0;
    endcase
  endfunction

  // one clock: drive at negedge, update model, settle after posedge
  task automatic cyc(input logic t, input logic w, input logic [7:0] a,
                     input logic [31:0] d, input logic m);
    logic ld, step, setc, setw;
    @(negedge clk);
    tick = t; we = w; wa = a; wd = d; wm = m;
    ld   = w && a == 8'h00;
    step = t && m_run && m_cnt != 0;
    setc = step && !ld && m_cnt == 1;
    setw = m && m_wen;
    if (setc) m_cp = 1; else if (w && a == 8'h0C && d[0]) m_cp = 0;
    if (setw) m_wp = 1; else if (w && a == 8'h1C && d[0]) m_wp = 0;
    if (ld) m_cnt = d; else if (step) m_cnt = m_cnt - 1;
    if (w) begin
      if (a == 8'h04) m_run  = d[0];
      if (a == 8'h08) m_cie  = d[0];
      if (a == 8'h10) m_wake = d[0];
      if (a == 8'h14) m_wen  = d[0];
      if (a == 8'h18) m_wie  = d[0];
    end
    @(posedge clk); #1;
    tick = 0; we = 0; wm = 0;
  endtask

  task automatic rd_chk(input string r, input logic [7:0] a);
    ra = a; #0.5;
    chk(r, rd, exp_read(a));
  endtask

  task automatic out_chk();
    chk("R7 irq_cnt", {31'd0, irq_c}, {31'd0, m_cp & m_cie});
    chk("R8 wake", {31'd0, wake}, {31'd0, m_cp & m_cie & m_wake});
    chk("R9 irq_week", {31'd0, irq_w}, {31'd0, m_wp & m_wie});
  endtask

  initial begin
    #200000;
    n_fail++;
    $display("FAIL watchdog actual running expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    m_cnt = 0; {m_run, m_cie, m_wake, m_wen, m_wie, m_cp, m_wp} = '0;
    repeat (3) @(posedge clk);
    #1; rst_n = 1;
    // R1 reset state
    for (int k = 0; k < 8; k++) rd_chk("R1 reset reg", 8'(k*4));
    chk("R1 outputs", {29'd0, irq_c, irq_w, wake}, 32'd0);

    // R2 load and readback
    cyc(0, 1, 8'h00, 32'd3, 0);
    rd_chk("R2 count load", 8'h00);
    // R3 no tick while disabled
    cyc(1, 0, 0, 0, 0);
    rd_chk("R3 hold disabled", 8'h00);
    cyc(0, 1, 8'h04, 32'hFFFF_FFFF, 0);
    cyc(0, 1, 8'h08, 1, 0);
    cyc(0, 1, 8'h10, 1, 0);
    rd_chk("R11 upper bits zero", 8'h04);
    cyc(1, 0, 0, 0, 0); rd_chk("R3 dec", 8'h00);
    cyc(0, 0, 0, 0, 0); rd_chk("R3 hold no tick", 8'h00);
    cyc(1, 0, 0, 0, 0);
    chk("R4 not yet pending", {31'd0, irq_c}, 32'd0);
    cyc(1, 0, 0, 0, 0);
    rd_chk("R4 reach zero", 8'h00);
    rd_chk("R4 pending set", 8'h0C);
    out_chk();
    // R5 write 0 no effect
    cyc(0, 1, 8'h0C, 0, 0); rd_chk("R5 write zero keeps", 8'h0C);
    cyc(0, 1, 8'h0C, 1, 0); rd_chk("R5 w1c", 8'h0C);
    // R4 held at zero with ticks never sets
    cyc(1, 0, 0, 0, 0); cyc(1, 0, 0, 0, 0);
    rd_chk("R4 zero no reset", 8'h0C);
    cyc(0, 1, 8'h00, 0, 0); rd_chk("R4 load zero", 8'h0C);
    // R6 set and clear same edge
    cyc(0, 1, 8'h00, 1, 0);
    cyc(1, 1, 8'h0C, 1, 0);
    rd_chk("R6 set wins", 8'h0C);
    out_chk();
    cyc(0, 1, 8'h0C, 1, 0);
    // R10 write count with tick
    cyc(0, 1, 8'h00, 1, 0);
    cyc(1, 1, 8'h00, 32'd9, 0);
    rd_chk("R10 write wins", 8'h00);
    rd_chk("R10 no pending", 8'h0C);
    // R9 weekly
    cyc(0, 0, 0, 0, 1); rd_chk("R9 match disabled", 8'h1C);
    cyc(0, 1, 8'h14, 1, 0); cyc(0, 1, 8'h18, 1, 0);
    cyc(0, 0, 0, 0, 1); rd_chk("R9 match sets", 8'h1C); out_chk();
    cyc(0, 1, 8'h1C, 1, 0); rd_chk("R9 clear", 8'h1C);
    // R11 unmapped
    cyc(0, 1, 8'h40, 32'hFFFF_FFFF, 0);
    rd_chk("R11 unmapped", 8'h40);
    for (int k = 0; k < 8; k++) rd_chk("R11 unmapped write harmless", 8'(k*4));

    // random phase
    for (int i = 0; i < 4000; i++) begin
      logic t, w, m;
      logic [7:0] a;
      logic [31:0] d;
      t = ($urandom % 3) == 0;
      w = ($urandom % 6) == 0;
      m = ($urandom % 20) == 0;
      a = 8'(($urandom % 9) * 4);
      d = (a == 8'h00) ? ($urandom % 6) : $urandom;
      cyc(t, w, a, d, m);
      out_chk();
      rd_chk("R3 random count", 8'h00);
      rd_chk("R5 random pend", 8'h0C);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule